// File: doc/BRIEF.md
# Shared-Pin Port Multiplexer

This block is an 8-bit general-purpose I/O port whose pins are shared by three possible owners. These are the port's own data register, a group of PWM channel outputs, and a group of timer output-compare channels. Each pin is given to one owner by a fixed rule. A peripheral that claims a pin always beats plain I/O. On the pins that both the PWM and the timer can reach, a per-pin routing bit picks which of the two wins. The block produces the drive value and the output enable for every pad. It does not contain the pads, the PWM generator or the timer.

Software uses a small register bus with single-cycle reads and a synchronous write strobe. It can reach four registers: the data register, a read-only view of the pin levels, the direction register and the routing register. Pad levels pass through a two-flop synchronizer before any register can read them. Reading the data register returns the stored bit on output pins and the synchronized pad level on input pins.

Top module: `shared_pin_port`

## Requirements
- R1: After reset, every output enable is 0. The data, direction and routing registers hold 0, and the direction and routing registers read back as 0x00.
- R2: Timer channel k (k = 0..3) drives pin k when the timer-enable input is 1 and the channel's output-compare enable bit k is 1. When the timer-enable input is 0, no timer channel drives any pin.
- R3: When PWM enable bit k (k = 0..5) is 1, PWM channel k drives pin k+2.
- R4: On pins 3 and 2, when the timer and the PWM both claim the pin, routing register bit 3 or bit 2 set to 1 gives that pin to the timer, and 0 gives it to the PWM. Routing bits other than 3 and 2 are not stored and read as 0.
- R5: A pin claimed by a peripheral has its output enable at 1 and drives the peripheral's value, whatever its direction bit holds. An unclaimed pin has its output enable equal to its direction bit and drives its data register bit.
- R6: Reading address 0 returns the stored data bit where the direction bit is 1, and the synchronized pin level where the direction bit is 0.
- R7: Reading address 1 returns the synchronized pin levels. A write to address 1 changes no register.
- R8: The addresses are data = 0, input status = 1, direction = 2, routing = 3. A write is taken on the clock edge where the write strobe is 1, and a read is visible in the same cycle as its address.
- R9: A change on a pad becomes visible to register reads after two rising clock edges, and not after one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pad_in | input | 8 | Levels seen at the pads |
| pwm_en | input | 6 | PWM channel enables, bit k for pin k+2 |
| pwm_val | input | 6 | PWM channel output values |
| tmr_on | input | 1 | Timer module enabled |
| tmr_oc_en | input | 4 | Timer channels set up for output compare |
| tmr_val | input | 4 | Timer output-compare values |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address |
| pad_out | output | 8 | Per-pin drive value |
| pad_oe | output | 8 | Per-pin output enable |

## Verification
The bench sets up both claims on pins 3 and 2 and flips the routing bits. A design that ignored routing, or decoded the bits the wrong way round, would hand the pin to the wrong peripheral. Peripheral-owned pins are also tested with their direction bit at 0 and at 1. A design that let the direction bit gate the enable would float a pin that a PWM or timer is driving. The data register is read with mixed directions, which catches a mux that returns the stored bit for input pins. A single-edge read after a pad change shows whether the synchronizer has the wrong depth. A write to the status address tests whether it wrongly updates the data or direction register.

// File: rtl/port_pkg.sv
package port_pkg;
   localparam logic [1:0] A_DATA   = 2'd0;
   localparam logic [1:0] A_STATUS = 2'd1;
   localparam logic [1:0] A_DIR    = 2'd2;
   localparam logic [1:0] A_ROUTE  = 2'd3;

   typedef enum logic [1:0] {OWN_GPIO = 2'd0, OWN_PWM = 2'd1, OWN_TMR = 2'd2} owner_e;

   // bit i set where both peripheral groups can reach pin i
   function automatic logic [63:0] overlap_mask(input int w, input int tl, input int tc,
                                                input int pl, input int pc);
      logic [63:0] m;
      m = '0;
      for (int i = 0; i < w; i++) begin
         if (i >= tl && i < tl + tc && i >= pl && i < pl + pc) m[i] = 1'b1;
      end
      return m;
   endfunction
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pin_sync needs at least two stages");
   end

   logic [WIDTH-1:0] st [STAGES];

   // no reset: levels stay whatever the pads show
   always_ff @(posedge clk) begin
      st[0] <= d;
   end

   for (genvar k = 1; k < STAGES; k++) begin : g_stage
      always_ff @(posedge clk) begin
         st[k] <= st[k-1];
      end
      p_sync_shift_r9: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> st[k] == $past(st[k-1]));
   end

   assign q = st[STAGES-1];

   p_sync_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> st[0] == $past(d));
endmodule

// File: rtl/port_regs.sv
module port_regs
   import port_pkg::*;
#(
   parameter int          WIDTH = 8,
   parameter logic [63:0] RMASK = 64'h0C
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       addr,
   input  logic             wr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [WIDTH-1:0] pin_sync,
   output logic [WIDTH-1:0] data_q,
   output logic [WIDTH-1:0] dir_q,
   output logic [WIDTH-1:0] route_q,
   output logic [WIDTH-1:0] rdata
);
   localparam logic [WIDTH-1:0] ROUTE_BITS = RMASK[WIDTH-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q  <= '0;
         dir_q   <= '0;
         route_q <= '0;
      end else if (wr) begin
         case (addr)
            A_DATA:  data_q  <= wdata;
            A_DIR:   dir_q   <= wdata;
            A_ROUTE: route_q <= wdata & ROUTE_BITS;
            default: ;
         endcase
      end
   end

   always_comb begin
      case (addr)
         A_DATA:   rdata = (data_q & dir_q) | (pin_sync & ~dir_q);
         A_STATUS: rdata = pin_sync;
         A_DIR:    rdata = dir_q;
         default:  rdata = route_q;
      endcase
   end

   p_wr_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == A_DATA) |=> data_q == $past(wdata));
   p_ro_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == A_STATUS) |=> ($stable(data_q) && $stable(dir_q) && $stable(route_q)));
   p_route_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && addr == A_ROUTE) |=> $stable(route_q));
endmodule

// File: rtl/pin_owner_arb.sv
module pin_owner_arb
   import port_pkg::*;
#(
   parameter int WIDTH   = 8,
   parameter int TMR_LSB = 0,
   parameter int TMR_CH  = 4,
   parameter int PWM_LSB = 2,
   parameter int PWM_CH  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WIDTH-1:0]  data_q,
   input  logic [WIDTH-1:0]  dir_q,
   input  logic [WIDTH-1:0]  route_q,
   input  logic [PWM_CH-1:0] pwm_en,
   input  logic [PWM_CH-1:0] pwm_val,
   input  logic              tmr_on,
   input  logic [TMR_CH-1:0] tmr_oc_en,
   input  logic [TMR_CH-1:0] tmr_val,
   output logic [WIDTH-1:0]  pad_out,
   output logic [WIDTH-1:0]  pad_oe
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      localparam bit IN_T = (i >= TMR_LSB) && (i < TMR_LSB + TMR_CH);
      localparam bit IN_P = (i >= PWM_LSB) && (i < PWM_LSB + PWM_CH);
      logic   t_claim, p_claim, t_v, p_v;
      owner_e own;

      if (IN_T) begin : g_t
         assign t_claim = tmr_on & tmr_oc_en[i-TMR_LSB];
         assign t_v     = tmr_val[i-TMR_LSB];
      end else begin : g_nt
         assign t_claim = 1'b0;
         assign t_v     = 1'b0;
      end

      if (IN_P) begin : g_p
         assign p_claim = pwm_en[i-PWM_LSB];
         assign p_v     = pwm_val[i-PWM_LSB];
      end else begin : g_np
         assign p_claim = 1'b0;
         assign p_v     = 1'b0;
      end

      always_comb begin
         if (t_claim && p_claim) own = route_q[i] ? OWN_TMR : OWN_PWM;
         else if (t_claim)       own = OWN_TMR;
         else if (p_claim)       own = OWN_PWM;
         else                    own = OWN_GPIO;
      end

      always_comb begin
         case (own)
            OWN_TMR: begin pad_oe[i] = 1'b1;     pad_out[i] = t_v;       end
            OWN_PWM: begin pad_oe[i] = 1'b1;     pad_out[i] = p_v;       end
            default: begin pad_oe[i] = dir_q[i]; pad_out[i] = data_q[i]; end
         endcase
      end

      p_periph_oe_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (t_claim || p_claim) |-> pad_oe[i]);
      p_gpio_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (!t_claim && !p_claim) |-> (pad_oe[i] == dir_q[i] && pad_out[i] == data_q[i]));
      p_route_pick_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (t_claim && p_claim) |-> pad_out[i] == (route_q[i] ? t_v : p_v));
   end
endmodule

// File: rtl/shared_pin_port.sv
module shared_pin_port
   import port_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter int TMR_LSB     = 0,
   parameter int TMR_CH      = 4,
   parameter int PWM_LSB     = 2,
   parameter int PWM_CH      = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WIDTH-1:0]  pad_in,
   input  logic [PWM_CH-1:0] pwm_en,
   input  logic [PWM_CH-1:0] pwm_val,
   input  logic              tmr_on,
   input  logic [TMR_CH-1:0] tmr_oc_en,
   input  logic [TMR_CH-1:0] tmr_val,
   input  logic [1:0]        bus_addr,
   input  logic              bus_wr,
   input  logic [WIDTH-1:0]  bus_wdata,
   output logic [WIDTH-1:0]  bus_rdata,
   output logic [WIDTH-1:0]  pad_out,
   output logic [WIDTH-1:0]  pad_oe
);
   localparam logic [63:0] RMASK = overlap_mask(WIDTH, TMR_LSB, TMR_CH, PWM_LSB, PWM_CH);

   if (WIDTH > 64 || TMR_LSB + TMR_CH > WIDTH || PWM_LSB + PWM_CH > WIDTH) begin : g_bad_map
      $error("peripheral channel range exceeds port width");
   end

   logic [WIDTH-1:0] pin_s, data_q, dir_q, route_q;

   pin_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_s));

   port_regs #(.WIDTH(WIDTH), .RMASK(RMASK)) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
      .pin_sync(pin_s), .data_q(data_q), .dir_q(dir_q), .route_q(route_q),
      .rdata(bus_rdata));

   pin_owner_arb #(.WIDTH(WIDTH), .TMR_LSB(TMR_LSB), .TMR_CH(TMR_CH),
                   .PWM_LSB(PWM_LSB), .PWM_CH(PWM_CH)) u_arb (
      .clk(clk), .rst_n(rst_n), .data_q(data_q), .dir_q(dir_q), .route_q(route_q),
      .pwm_en(pwm_en), .pwm_val(pwm_val), .tmr_on(tmr_on), .tmr_oc_en(tmr_oc_en),
      .tmr_val(tmr_val), .pad_out(pad_out), .pad_oe(pad_oe));

   p_status_view_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == A_STATUS) |-> bus_rdata == pin_s);
   p_tmr_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!tmr_on && pwm_en == '0) |-> pad_oe == dir_q);
endmodule

// File: tb/sim_shared_pin_port.sv
`timescale 1ns/1ps
module sim_shared_pin_port;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] pad_in = '0;
   logic [5:0] pwm_en = '0, pwm_val = '0;
   logic       tmr_on = 1'b0;
   logic [3:0] tmr_oc_en = '0, tmr_val = '0;
   logic [1:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata, pad_out, pad_oe;

   int checks = 0, failures = 0;
   bit done = 1'b0;

   typedef struct {
      logic [7:0] exp;
      string      tag;
   } item_t;
   item_t sb[$];

   always #4 clk = ~clk;

   shared_pin_port u0 (
      .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .pwm_en(pwm_en), .pwm_val(pwm_val),
      .tmr_on(tmr_on), .tmr_oc_en(tmr_oc_en), .tmr_val(tmr_val), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pad_out(pad_out), .pad_oe(pad_oe));

   // monitor: compare each read result in its own cycle
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (bus_rdata !== it.exp) begin
               failures++;
               $display("FAIL %s rdata=%02h expected=%02h", it.tag, bus_rdata, it.exp);
            end
         end
      end
   end

   task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
      item_t it;
      @(negedge clk);
      bus_addr = a;
      it.exp = exp;
      it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic pins(input logic [7:0] eoe, input logic [7:0] eout, input string tag);
      @(negedge clk);
      #2;
      checks++;
      if (pad_oe !== eoe || (pad_out & eoe) !== (eout & eoe)) begin
         failures++;
         $display("FAIL %s oe=%02h out=%02h expected oe=%02h out=%02h",
                  tag, pad_oe, pad_out & eoe, eoe, eout & eoe);
      end
   endtask

   task automatic finish_up;
      if (!done) begin
         done = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      finish_up();
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      pins(8'h00, 8'h00, "R1 oe after reset");
      rd(2'd2, 8'h00, "R1 dir reset");
      rd(2'd3, 8'h00, "R1 route reset");
      rd(2'd0, 8'h00, "R1 data reset");
      // R8 / R6 mixed directions
      pad_in = 8'h3C;
      wr(2'd2, 8'hF0);
      wr(2'd0, 8'hA5);
      rd(2'd2, 8'hF0, "R8 dir write");
      rd(2'd0, 8'hAC, "R6 mixed read");
      pins(8'hF0, 8'hA0, "R5 gpio follows dir/data");
      // R7 status read only
      rd(2'd1, 8'h3C, "R7 status view");
      wr(2'd1, 8'hFF);
      rd(2'd2, 8'hF0, "R7 status write leaves dir");
      rd(2'd0, 8'hAC, "R7 status write leaves data");
      // R9 synchronizer depth
      @(negedge clk);
      pad_in = 8'h5A;
      rd(2'd1, 8'h3C, "R9 one edge old");
      rd(2'd1, 8'h5A, "R9 two edges new");
      // R2 timer channels
      tmr_oc_en = 4'b0101; tmr_val = 4'b0001; tmr_on = 1'b1;
      pins(8'hF5, 8'hA1, "R2 timer drives 0 and 2");
      tmr_on = 1'b0;
      pins(8'hF0, 8'hA0, "R2 timer disabled");
      tmr_oc_en = 4'b0000;
      // R3 / R5 PWM with dir cleared
      wr(2'd2, 8'h00);
      pwm_en = 6'b100001; pwm_val = 6'b100000;
      pins(8'h84, 8'h80, "R3 pwm pins 7 and 2");
      // R5 dir set, PWM drives 0 over data 1
      wr(2'd2, 8'hFF);
      wr(2'd0, 8'h80);
      pwm_val = 6'b000000;
      pins(8'hFF, 8'h00, "R5 peripheral beats data");
      // R4 overlap arbitration
      wr(2'd2, 8'h00);
      tmr_on = 1'b1; tmr_oc_en = 4'b1100; tmr_val = 4'b1100;
      pwm_en = 6'b000011; pwm_val = 6'b000000;
      pins(8'h0C, 8'h00, "R4 route 0 gives pwm");
      wr(2'd3, 8'hFF);
      rd(2'd3, 8'h0C, "R4 route only bits 3 and 2");
      pins(8'h0C, 8'h0C, "R4 route 1 gives timer");
      wr(2'd3, 8'h04);
      pins(8'h0C, 8'h04, "R4 split route");
      tmr_on = 1'b0; pwm_en = '0;
      pins(8'h00, 8'h00, "R5 release to gpio");
      while (sb.size() > 0) @(negedge clk);
      @(negedge clk);
      finish_up();
   end
endmodule